// File: doc/BRIEF.md
# Exception and Interrupt Entry Controller

This block makes the single-step decision of how a processor core enters a handler. On each cycle with `step_i` high it looks at a pending exception code, a pending hardware interrupt and the core's current status. It then commits the whole entry at the next clock edge: the saved copies of status, program counter and stack pointer, the event code registers, the updated status word and the handler address. The alternative outcomes are a reset request, with nothing else changed, or no action at all.

The interrupt vector comes from an external interrupt controller. The block drives the current mask level (status bits [7:4]) on `irq_level_o`, and the controller answers combinationally with a vector and a valid flag. A missing answer means the interrupt is masked. The core reads the registered outputs after a `take_o` pulse. That pulse also tells the core to clear its sleep flag. `dslot_clr_o` tells the core to clear its delay-slot flag.

Top module: `exc_entry_ctrl`

## Requirements
- R1: After reset all registered outputs are zero. `take_o`, `reset_req_o` and `dslot_clr_o` are pulses, and the held registers keep their values when no entry is taken.
- R2: A pending exception is taken in preference to a pending interrupt. When both are pending, `intevt_o` keeps its value and `expevt_o` receives the exception code.
- R3: With status bit 28 (block) set, an exception whose code is not 0x1E0 raises `reset_req_o` for one cycle, and no held register changes. Code 0x1E0 is taken normally under block.
- R4: With the block bit set, an interrupt is ignored unless `sleep_i` is high. A hardware interrupt is never taken while `dslot_i` is high.
- R5: `irq_level_o` equals status bits [7:4]. When `irq_vec_valid_i` is low, a pending interrupt causes no change.
- R6: On every entry, SSR receives the old status, SGR receives `r15_i`, and the new status is the old one with bits 30, 29 and 28 set.
- R7: SPC receives `pc_i`. It is reduced by 2 when `dslot_i` is high, in which case `dslot_clr_o` pulses.
- R8: Exception codes 0x000, 0x020 and 0x140 jump to 0xA0000000. They also clear status bit 15 and force status bits [7:4] to 0xF.
- R9: Codes 0x040 and 0x060 jump to VBR+0x400. Every other exception code jumps to VBR+0x100, and code 0x160 additionally adds 2 to SPC.
- R10: An interrupt loads `intevt_o` with the vector and jumps to VBR+0x600. An exception loads `expevt_o` with its code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| step_i | input | 1 | Evaluate pending events this cycle |
| exc_valid_i | input | 1 | An exception is pending |
| exc_code_i | input | 12 | Pending exception code |
| irq_req_i | input | 1 | A hardware interrupt is pending |
| irq_level_o | output | 4 | Mask level sent to the interrupt controller |
| irq_vec_valid_i | input | 1 | Controller has an unmasked vector |
| irq_vec_i | input | 12 | Interrupt vector from the controller |
| sr_i | input | 32 | Current status word |
| pc_i | input | 32 | Current program counter |
| r15_i | input | 32 | Current stack pointer |
| vbr_i | input | 32 | Vector base |
| sleep_i | input | 1 | Core is sleeping |
| dslot_i | input | 1 | Current instruction is in a delay slot |
| take_o | output | 1 | Entry committed (also clears sleep) |
| reset_req_o | output | 1 | Reset requested |
| dslot_clr_o | output | 1 | Clear the delay-slot flag |
| pc_o | output | 32 | Handler address |
| sr_o | output | 32 | Updated status word |
| ssr_o | output | 32 | Saved status |
| spc_o | output | 32 | Saved program counter |
| sgr_o | output | 32 | Saved stack pointer |
| expevt_o | output | 12 | Exception event code |
| intevt_o | output | 12 | Interrupt event code |

## Verification
Directed steps apply one code from each handler class. Together they separate the fixed reset-class address, the VBR+0x400 offset, the VBR+0x100 offset and the interrupt offset, and they show the status rewrites that only the reset class performs. Further steps pair a trap with a delay slot so that the two SPC adjustments are distinguished, and combine the block bit with sleep, a masked vector and the escape code. Random steps over status, codes, flags and vectors then compare every output against a bench model. This exposes arbitration errors, such as an interrupt winning over an exception or an entry taken under block, that the directed cases miss.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
    localparam int SR_MD_BIT = 30;
    localparam int SR_RB_BIT = 29;
    localparam int SR_BL_BIT = 28;
    localparam int SR_FD_BIT = 15;
    localparam int SR_IM_LSB = 4;
    localparam int SR_IM_W   = 4;

    localparam logic [11:0] CODE_PWR_RST  = 12'h000;
    localparam logic [11:0] CODE_MAN_RST  = 12'h020;
    localparam logic [11:0] CODE_MULTI    = 12'h140;
    localparam logic [11:0] CODE_MISS_RD  = 12'h040;
    localparam logic [11:0] CODE_MISS_WR  = 12'h060;
    localparam logic [11:0] CODE_TRAP     = 12'h160;
    localparam logic [11:0] CODE_ESCAPE   = 12'h1E0;

    localparam logic [11:0] OFS_GENERAL = 12'h100;
    localparam logic [11:0] OFS_MISS    = 12'h400;
    localparam logic [11:0] OFS_IRQ     = 12'h600;

    typedef enum logic [1:0] {
        ENT_NONE = 2'd0,
        ENT_EXC  = 2'd1,
        ENT_IRQ  = 2'd2,
        ENT_RST  = 2'd3
    } entry_kind_e;
endpackage

// File: rtl/exc_entry_arbiter.sv
module exc_entry_arbiter
    import exc_entry_pkg::*;
#(
    parameter int CODE_W = 12
) (
    input  logic              step_i,
    input  logic              exc_valid_i,
    input  logic [CODE_W-1:0] exc_code_i,
    input  logic              irq_req_i,
    input  logic              irq_vec_valid_i,
    input  logic              blocked_i,
    input  logic              sleep_i,
    input  logic              dslot_i,
    output entry_kind_e       kind_o
);
    logic irq_ok;

    always_comb begin
        irq_ok = irq_req_i && !dslot_i && (!blocked_i || sleep_i) && irq_vec_valid_i;
        kind_o = ENT_NONE;
        if (step_i) begin
            if (exc_valid_i) begin
                if (blocked_i && (exc_code_i != CODE_W'(CODE_ESCAPE)))
                    kind_o = ENT_RST;
                else
                    kind_o = ENT_EXC;
            end else if (irq_ok) begin
                kind_o = ENT_IRQ;
            end
        end
    end
endmodule

// File: rtl/exc_entry_target.sv
module exc_entry_target
    import exc_entry_pkg::*;
#(
    parameter int          XLEN     = 32,
    parameter int          CODE_W   = 12,
    parameter logic [31:0] RESET_PC = 32'hA000_0000
) (
    input  entry_kind_e       kind_i,
    input  logic [CODE_W-1:0] exc_code_i,
    input  logic [XLEN-1:0]   sr_i,
    input  logic [XLEN-1:0]   pc_i,
    input  logic [XLEN-1:0]   vbr_i,
    input  logic              dslot_i,
    output logic [XLEN-1:0]   new_pc_o,
    output logic [XLEN-1:0]   new_sr_o,
    output logic [XLEN-1:0]   saved_pc_o
);
    logic reset_class, miss_class, trap;
    logic [XLEN-1:0] ofs;

    always_comb begin
        reset_class = (exc_code_i == CODE_W'(CODE_PWR_RST)) ||
                      (exc_code_i == CODE_W'(CODE_MAN_RST)) ||
                      (exc_code_i == CODE_W'(CODE_MULTI));
        miss_class  = (exc_code_i == CODE_W'(CODE_MISS_RD)) ||
                      (exc_code_i == CODE_W'(CODE_MISS_WR));
        trap        = (kind_i == ENT_EXC) && (exc_code_i == CODE_W'(CODE_TRAP));

        new_sr_o = sr_i;
        new_sr_o[SR_MD_BIT] = 1'b1;
        new_sr_o[SR_RB_BIT] = 1'b1;
        new_sr_o[SR_BL_BIT] = 1'b1;

        saved_pc_o = pc_i;
        if (dslot_i) saved_pc_o = saved_pc_o - XLEN'(2);
        if (trap)    saved_pc_o = saved_pc_o + XLEN'(2);

        if (kind_i == ENT_IRQ)  ofs = XLEN'(OFS_IRQ);
        else if (miss_class)    ofs = XLEN'(OFS_MISS);
        else                    ofs = XLEN'(OFS_GENERAL);
        new_pc_o = vbr_i + ofs;

        if ((kind_i == ENT_EXC) && reset_class) begin
            new_pc_o = XLEN'(RESET_PC);
            new_sr_o[SR_FD_BIT] = 1'b0;
            new_sr_o[SR_IM_LSB +: SR_IM_W] = '1;
        end
    end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
    import exc_entry_pkg::*;
#(
    parameter int          XLEN     = 32,
    parameter int          CODE_W   = 12,
    parameter logic [31:0] RESET_PC = 32'hA000_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_i,
    input  logic              exc_valid_i,
    input  logic [CODE_W-1:0] exc_code_i,
    input  logic              irq_req_i,
    output logic [3:0]        irq_level_o,
    input  logic              irq_vec_valid_i,
    input  logic [CODE_W-1:0] irq_vec_i,
    input  logic [XLEN-1:0]   sr_i,
    input  logic [XLEN-1:0]   pc_i,
    input  logic [XLEN-1:0]   r15_i,
    input  logic [XLEN-1:0]   vbr_i,
    input  logic              sleep_i,
    input  logic              dslot_i,
    output logic              take_o,
    output logic              reset_req_o,
    output logic              dslot_clr_o,
    output logic [XLEN-1:0]   pc_o,
    output logic [XLEN-1:0]   sr_o,
    output logic [XLEN-1:0]   ssr_o,
    output logic [XLEN-1:0]   spc_o,
    output logic [XLEN-1:0]   sgr_o,
    output logic [CODE_W-1:0] expevt_o,
    output logic [CODE_W-1:0] intevt_o
);
    typedef struct packed {
        logic              take;
        logic              rst_req;
        logic              dclr;
        logic [XLEN-1:0]   pc;
        logic [XLEN-1:0]   sr;
        logic [XLEN-1:0]   ssr;
        logic [XLEN-1:0]   spc;
        logic [XLEN-1:0]   sgr;
        logic [CODE_W-1:0] expevt;
        logic [CODE_W-1:0] intevt;
    } state_t;

    state_t      st_d, st_q;
    entry_kind_e kind;
    logic [XLEN-1:0] tgt_pc, tgt_sr, tgt_spc;

    assign irq_level_o = sr_i[SR_IM_LSB +: SR_IM_W];

    exc_entry_arbiter #(.CODE_W(CODE_W)) u_arb (
        .step_i          (step_i),
        .exc_valid_i     (exc_valid_i),
        .exc_code_i      (exc_code_i),
        .irq_req_i       (irq_req_i),
        .irq_vec_valid_i (irq_vec_valid_i),
        .blocked_i       (sr_i[SR_BL_BIT]),
        .sleep_i         (sleep_i),
        .dslot_i         (dslot_i),
        .kind_o          (kind)
    );

    exc_entry_target #(.XLEN(XLEN), .CODE_W(CODE_W), .RESET_PC(RESET_PC)) u_tgt (
        .kind_i     (kind),
        .exc_code_i (exc_code_i),
        .sr_i       (sr_i),
        .pc_i       (pc_i),
        .vbr_i      (vbr_i),
        .dslot_i    (dslot_i),
        .new_pc_o   (tgt_pc),
        .new_sr_o   (tgt_sr),
        .saved_pc_o (tgt_spc)
    );

    always_comb begin
        st_d         = st_q;
        st_d.take    = 1'b0;
        st_d.rst_req = 1'b0;
        st_d.dclr    = 1'b0;
        if (kind == ENT_RST) begin
            st_d.rst_req = 1'b1;
        end else if (kind != ENT_NONE) begin
            st_d.take = 1'b1;
            st_d.dclr = dslot_i;
            st_d.pc   = tgt_pc;
            st_d.sr   = tgt_sr;
            st_d.ssr  = sr_i;
            st_d.spc  = tgt_spc;
            st_d.sgr  = r15_i;
            if (kind == ENT_EXC) st_d.expevt = exc_code_i;
            else                 st_d.intevt = irq_vec_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign take_o      = st_q.take;
    assign reset_req_o = st_q.rst_req;
    assign dslot_clr_o = st_q.dclr;
    assign pc_o        = st_q.pc;
    assign sr_o        = st_q.sr;
    assign ssr_o       = st_q.ssr;
    assign spc_o       = st_q.spc;
    assign sgr_o       = st_q.sgr;
    assign expevt_o    = st_q.expevt;
    assign intevt_o    = st_q.intevt;

    assert_reset_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req_o |-> (!take_o && $stable(pc_o) && $stable(sr_o) && $stable(spc_o)));

    assert_block_escalates_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && exc_valid_i && sr_i[SR_BL_BIT] && exc_code_i != CODE_W'(CODE_ESCAPE))
        |=> reset_req_o);

    assert_sr_bits_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> (sr_o[SR_MD_BIT] && sr_o[SR_RB_BIT] && sr_o[SR_BL_BIT]));

    assert_exc_priority_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && exc_valid_i && irq_req_i) |=> $stable(intevt_o));

    assert_dslot_irq_blocked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !exc_valid_i && dslot_i) |=> !take_o);

    assert_irq_target_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !exc_valid_i && irq_req_i && irq_vec_valid_i && !dslot_i && !sr_i[SR_BL_BIT])
        |=> (take_o && pc_o == $past(vbr_i) + XLEN'(OFS_IRQ) && intevt_o == $past(irq_vec_i)));

    assert_pulse_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({take_o, reset_req_o}));
endmodule

// File: tb/exc_entry_ctrl_test.sv
module exc_entry_ctrl_test;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0, rst_n = 1'b0;
    logic step, exc_v, irq_req, vec_v, sleep, dslot;
    logic [11:0] code, vec;
    logic [31:0] sr, pc, r15, vbr;
    logic [3:0] lvl;
    logic take, rreq, dclr;
    logic [31:0] pc_o, sr_o, ssr_o, spc_o, sgr_o;
    logic [11:0] expevt, intevt;

    int n_chk = 0, n_bad = 0;

    logic [31:0] e_pc, e_sr, e_ssr, e_spc, e_sgr;
    logic [11:0] e_exp, e_int;
    logic e_take, e_rreq, e_dclr;

    always #(CLK_PERIOD/2) clk = ~clk;

    exc_entry_ctrl uut (
        .clk(clk), .rst_n(rst_n), .step_i(step), .exc_valid_i(exc_v), .exc_code_i(code),
        .irq_req_i(irq_req), .irq_level_o(lvl), .irq_vec_valid_i(vec_v), .irq_vec_i(vec),
        .sr_i(sr), .pc_i(pc), .r15_i(r15), .vbr_i(vbr), .sleep_i(sleep), .dslot_i(dslot),
        .take_o(take), .reset_req_o(rreq), .dslot_clr_o(dclr), .pc_o(pc_o), .sr_o(sr_o),
        .ssr_o(ssr_o), .spc_o(spc_o), .sgr_o(sgr_o), .expevt_o(expevt), .intevt_o(intevt)
    );

    initial begin
        #(CLK_PERIOD * 20000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] sr_entry(input logic [31:0] s);
        return s | 32'h7000_0000;
    endfunction

    // Reference model: update expected state from the current inputs
    task automatic model();
        logic bl, reset_cls;
        bl = sr[28];
        e_take = 0; e_rreq = 0; e_dclr = 0;
        if (!step) return;
        if (exc_v) begin
            if (bl && code != 12'h1E0) begin e_rreq = 1; return; end
            e_take = 1; e_dclr = dslot;
            e_ssr = sr; e_sgr = r15; e_exp = code;
            e_spc = pc - (dslot ? 32'd2 : 32'd0) + ((code == 12'h160) ? 32'd2 : 32'd0);
            e_sr = sr_entry(sr);
            reset_cls = (code == 12'h000) || (code == 12'h020) || (code == 12'h140);
            if (reset_cls) begin
                e_pc = 32'hA000_0000;
                e_sr[15] = 1'b0; e_sr[7:4] = 4'hF;
            end else if (code == 12'h040 || code == 12'h060) e_pc = vbr + 32'h400;
            else e_pc = vbr + 32'h100;
        end else if (irq_req && !dslot && (!bl || sleep) && vec_v) begin
            e_take = 1;
            e_ssr = sr; e_sgr = r15; e_spc = pc; e_sr = sr_entry(sr);
            e_int = vec; e_pc = vbr + 32'h600;
        end
    endtask

    task automatic compare(input string req);
        chk(req, "take", {31'd0, take}, {31'd0, e_take});
        chk(req, "reset_req", {31'd0, rreq}, {31'd0, e_rreq});
        chk(req, "dslot_clr", {31'd0, dclr}, {31'd0, e_dclr});
        chk(req, "pc", pc_o, e_pc);
        chk(req, "sr", sr_o, e_sr);
        chk(req, "ssr", ssr_o, e_ssr);
        chk(req, "spc", spc_o, e_spc);
        chk(req, "sgr", sgr_o, e_sgr);
        chk(req, "expevt", {20'd0, expevt}, {20'd0, e_exp});
        chk(req, "intevt", {20'd0, intevt}, {20'd0, e_int});
    endtask

    task automatic apply(input string req);
        @(negedge clk);
        chk("R5", "irq_level", {28'd0, lvl}, {28'd0, sr[7:4]});
        model();
        @(posedge clk);
        @(negedge clk);
        step = 0;
        compare(req);
    endtask

    task automatic set(input logic ev, input logic [11:0] c, input logic iq, input logic vv,
                       input logic [31:0] s, input logic sl, input logic ds);
        step = 1; exc_v = ev; code = c; irq_req = iq; vec_v = vv; sr = s; sleep = sl; dslot = ds;
    endtask

    initial begin
        logic [11:0] codes [10];
        codes = '{12'h000, 12'h020, 12'h140, 12'h040, 12'h060, 12'h160,
                  12'h1E0, 12'h0A0, 12'h180, 12'h800};
        void'($urandom(32'd1234));
        step = 0; exc_v = 0; irq_req = 0; vec_v = 0; sleep = 0; dslot = 0;
        code = 0; vec = 12'h3C0; sr = 32'h0000_00F0; pc = 32'h8C00_1000;
        r15 = 32'h8CFF_FF00; vbr = 32'h8C00_0000;
        e_pc = 0; e_sr = 0; e_ssr = 0; e_spc = 0; e_sgr = 0; e_exp = 0; e_int = 0;
        e_take = 0; e_rreq = 0; e_dclr = 0;
        repeat (3) @(negedge clk);
        compare("R1");
        rst_n = 1;

        // R8: reset-class codes
        set(1, 12'h140, 0, 0, 32'h0000_8030, 0, 0); apply("R8");
        // R9: miss class and general
        set(1, 12'h060, 0, 0, 32'h0000_0050, 0, 0); apply("R9");
        set(1, 12'h180, 0, 0, 32'h0000_0050, 0, 0); apply("R9");
        // R9 + R7: trap in delay slot, both adjustments
        set(1, 12'h160, 0, 0, 32'h0000_0000, 0, 1); apply("R7");
        // R10: interrupt entry
        vec = 12'h240; set(0, 0, 1, 1, 32'h0000_0070, 0, 0); apply("R10");
        // R2: exception and interrupt together
        set(1, 12'h0A0, 1, 1, 32'h0000_0070, 0, 0); apply("R2");
        // R3: block escalates to reset, escape code still taken
        set(1, 12'h040, 0, 0, 32'h1000_0000, 0, 0); apply("R3");
        set(1, 12'h1E0, 0, 0, 32'h1000_0000, 0, 0); apply("R3");
        // R4: block without sleep ignored, with sleep taken, delay slot blocks
        set(0, 0, 1, 1, 32'h1000_0000, 0, 0); apply("R4");
        vec = 12'h5A0; set(0, 0, 1, 1, 32'h1000_0000, 1, 0); apply("R4");
        set(0, 0, 1, 1, 32'h0000_0000, 0, 1); apply("R4");
        // R5: masked vector
        set(0, 0, 1, 0, 32'h0000_00F0, 0, 0); apply("R5");
        // R1: no step, held state
        set(1, 12'h180, 1, 1, 32'h0, 0, 0); step = 0; apply("R1");

        for (int i = 0; i < 400; i++) begin
            set($urandom_range(0, 1), codes[$urandom_range(0, 9)], $urandom_range(0, 1),
                $urandom_range(0, 1), $urandom, $urandom_range(0, 1), $urandom_range(0, 3) == 0);
            step = ($urandom_range(0, 7) != 0);
            pc = $urandom & 32'hFFFF_FFFE; r15 = $urandom;
            vbr = $urandom & 32'hFFFF_F000; vec = 12'($urandom) & 12'hFE0;
            apply("R6");
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule